// File: doc/BRIEF.md
# USB Controller Interrupt Aggregation Unit

This block collects single-cycle event pulses from a dual-role USB controller core and merges them into one active-low interrupt line. Every event source has a sticky status bit that software clears by writing zero, and an enable bit that decides whether that status may pull the line low. Three event kinds arrive per pipe: buffer ready, not ready and buffer empty. Each kind has its own per-pipe status and enable registers, and these feed one composite status bit. The device-state and control-stage sources have a second level of sub-factor enables. A sub-factor decides whether its event raises the composite status at all.

The core's current role (host or peripheral) and a low-power sleep flag restrict which sources count. Device-state and control-stage sources belong to peripheral mode only. Detach and setup-handshake sources belong to host mode only. While asleep, only the VBUS, resume and bus-change sources remain live. The block also tracks a 3-bit device state from the sub-factor events, whether or not those sub-factors are enabled, and exposes it for reading.

Top module: `usb_irq_hub`

## Requirements
- R1: After reset, every enable, status and per-pipe register reads 0, the device state reads 0 (powered) and `irq_n` is 1.
- R2: A permitted event pulse sampled at clock edge k sets its status bit at edge k. The bit stays set until cleared. Group 0 status (address 7) has this layout: bit0 VBUS, bit1 resume, bit2 SOF, bit3 device-state, bit4 control-stage, bit5 empty, bit6 not-ready, bit7 ready. Group 1 status (address 8) has this layout: bit0 bus change, bit1 detach, bit2 setup no-ACK, bit3 setup ACK.
- R3: A write to a status register clears every bit written as 0 and keeps every bit written as 1. An event in the same cycle as a clear leaves its bit set.
- R4: `irq_n` is registered. At edge k+1 it goes low if and only if, after edge k, some status bit is set whose enable is set and whose source is permitted. Group 0 enables sit at address 0 and group 1 enables at address 1, with the same bit layout as the matching status register.
- R5: A per-kind event sets the pipe's own status bit whatever that pipe's enable is. The composite bit is set only by pipes whose enable is 1. Per-pipe enables sit at addresses 4, 5 and 6, and per-pipe status at addresses 9, 10 and 11, in the order ready, not-ready, empty. Bit i of each register is pipe i.
- R6: The device-state composite bit is set only by a sub-factor event whose enable bit is 1. The enable register is at address 2, with bit0 bus reset, bit1 address set, bit2 configured and bit3 suspend.
- R7: The device state is read at address 12. Bits [1:0] hold the stage: 0 powered, 1 default, 2 address, 3 configured. Bit 2 is the suspended flag. In peripheral mode while awake, bus reset gives stage 1 and clears the flag. Configured gives stage 3, and address set gives stage 2, with priority in that order. Suspend sets the flag. A resume event clears the flag in peripheral mode, asleep or not. None of this depends on the sub-factor enables.
- R8: The control-stage composite bit is set only by a sub-factor event whose enable bit is 1. The enable register is at address 3, with bit0 write-data, bit1 read-data, bit2 status complete and bit3 sequence error.
- R9: In host mode, device-state and control-stage events set no status and leave the device state unchanged. Their status bits never drive `irq_n` low in host mode.
- R10: Detach, setup no-ACK and setup ACK set status and drive `irq_n` only in host mode.
- R11: Bus change sets status and can drive `irq_n` in both host and peripheral mode.
- R12: While `sleep_i` is 1, only VBUS, resume and bus change set status and drive `irq_n`. All other events change no status bit, per-pipe bit or device state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host role, 0 = peripheral role |
| sleep_i | input | 1 | Low-power sleep flag |
| ev_vbus | input | 1 | VBUS change event pulse |
| ev_resume | input | 1 | Resume event pulse |
| ev_sof | input | 1 | Start-of-frame event pulse |
| ev_dsub | input | 4 | Device-state sub-factor pulses (reset, address, configured, suspend) |
| ev_csub | input | 4 | Control-stage sub-factor pulses (write data, read data, complete, sequence error) |
| ev_brdy | input | NPIPE | Per-pipe buffer-ready pulses |
| ev_nrdy | input | NPIPE | Per-pipe not-ready pulses |
| ev_bemp | input | NPIPE | Per-pipe buffer-empty pulses |
| ev_bchg | input | 1 | Bus change event pulse |
| ev_detach | input | 1 | Full-speed detach event pulse |
| ev_setup_err | input | 1 | Setup sent, no ACK returned |
| ev_setup_ack | input | 1 | Setup sent, ACK returned |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DW | Combinational read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status bit or per-pipe bit is visible on `rd_data` right after the edge that sampled its event or write. `irq_n` answers one edge later. The bench therefore drives each pulse or write for exactly one cycle, starting 1 time unit after a rising edge. It reads status 1 unit after the capturing edge. It checks the pin only after one more edge, and sometimes checks first that the pin has not yet moved. Enable writes are treated in the same way: the pin reflects a new enable one edge after the write edge.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

  localparam int AW = 4;
  localparam int N0 = 8;
  localparam int N1 = 4;
  localparam int NSUB = 4;

  // group 0 status / enable bit positions
  localparam int S0_VBUS = 0;
  localparam int S0_RESM = 1;
  localparam int S0_SOF  = 2;
  localparam int S0_DVST = 3;
  localparam int S0_CTRT = 4;
  localparam int S0_BEMP = 5;
  localparam int S0_NRDY = 6;
  localparam int S0_BRDY = 7;

  // group 1 status / enable bit positions
  localparam int S1_BCHG = 0;
  localparam int S1_DTCH = 1;
  localparam int S1_SERR = 2;
  localparam int S1_SACK = 3;

  typedef enum logic [AW-1:0] {
    A_EN0     = 4'd0,
    A_EN1     = 4'd1,
    A_DSEN    = 4'd2,
    A_CSEN    = 4'd3,
    A_BRDYEN  = 4'd4,
    A_NRDYEN  = 4'd5,
    A_BEMPEN  = 4'd6,
    A_STS0    = 4'd7,
    A_STS1    = 4'd8,
    A_BRDYSTS = 4'd9,
    A_NRDYSTS = 4'd10,
    A_BEMPSTS = 4'd11,
    A_DEVST   = 4'd12
  } reg_addr_e;

  // bit2 = suspended, bits[1:0] = stage
  localparam logic [1:0] STG_POWERED    = 2'd0;
  localparam logic [1:0] STG_DEFAULT    = 2'd1;
  localparam logic [1:0] STG_ADDRESS    = 2'd2;
  localparam logic [1:0] STG_CONFIGURED = 2'd3;

  // Sub-factor order: 0 bus reset, 1 address set, 2 configured, 3 suspend
  function automatic logic [2:0] next_dev_state(input logic [2:0] cur,
                                                input logic [NSUB-1:0] sub,
                                                input logic resume);
    logic [1:0] stage;
    logic       susp;
    stage = cur[1:0];
    susp  = cur[2];
    if (sub[0]) begin
      stage = STG_DEFAULT;
      susp  = 1'b0;
    end else if (sub[2]) begin
      stage = STG_CONFIGURED;
    end else if (sub[1]) begin
      stage = STG_ADDRESS;
    end
    if (sub[3])      susp = 1'b1;
    else if (resume) susp = 1'b0;
    return {susp, stage};
  endfunction

  // Which group 0 sources are live for the given role and sleep flag
  function automatic logic [N0-1:0] live_mask0(input logic host, input logic sleep);
    logic [N0-1:0] m;
    m = '1;
    if (host) begin
      m[S0_DVST] = 1'b0;
      m[S0_CTRT] = 1'b0;
    end
    if (sleep) begin
      m = '0;
      m[S0_VBUS] = 1'b1;
      m[S0_RESM] = 1'b1;
    end
    return m;
  endfunction

  // Which group 1 sources are live for the given role and sleep flag
  function automatic logic [N1-1:0] live_mask1(input logic host, input logic sleep);
    logic [N1-1:0] m;
    m = '0;
    m[S1_BCHG] = 1'b1;
    if (host && !sleep) begin
      m[S1_DTCH] = 1'b1;
      m[S1_SERR] = 1'b1;
      m[S1_SACK] = 1'b1;
    end
    return m;
  endfunction

  // Sticky update: written zeros clear, events win
  function automatic logic [N0-1:0] sticky8(input logic [N0-1:0] cur, input logic we,
                                            input logic [N0-1:0] wd, input logic [N0-1:0] set);
    return (we ? (cur & wd) : cur) | set;
  endfunction

endpackage

// File: rtl/usbirq_pipe_bank.sv
module usbirq_pipe_bank #(
  parameter int NPIPE = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic [NPIPE-1:0] ev,
  input  logic             en_we,
  input  logic             sts_we,
  input  logic [NPIPE-1:0] wdata,
  output logic [NPIPE-1:0] en,
  output logic [NPIPE-1:0] sts,
  output logic             hit
);

  logic [NPIPE-1:0] ev_ok;
  logic [NPIPE-1:0] sts_nx;

  assign ev_ok = allow ? ev : '0;
  assign hit   = |(ev_ok & en);

  always_comb begin
    sts_nx = sts;
    for (int i = 0; i < NPIPE; i++) begin
      if (sts_we && !wdata[i]) sts_nx[i] = 1'b0;
      if (ev_ok[i])            sts_nx[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      sts <= '0;
    end else begin
      if (en_we) en <= wdata;
      sts <= sts_nx;
    end
  end

  AST_PIPE_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && ev != '0) |=> ((sts & $past(ev)) == $past(ev))); // R5
  AST_PIPE_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow && !sts_we) |=> (sts == $past(sts))); // R12

endmodule

// File: rtl/usbirq_subgate.sv
module usbirq_subgate #(
  parameter int NSUB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allow,
  input  logic [NSUB-1:0] ev,
  input  logic            en_we,
  input  logic [NSUB-1:0] wdata,
  output logic [NSUB-1:0] en,
  output logic            hit
);

  assign hit = allow && ((ev & en) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_we) en <= wdata;
  end

endmodule

// File: rtl/usbirq_devtrack.sv
module usbirq_devtrack
  import usbirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allow_sub,
  input  logic [NSUB-1:0] sub,
  input  logic            resume_ok,
  output logic [2:0]      state
);

  logic [NSUB-1:0] sub_ok;
  logic [2:0]      state_nx;

  assign sub_ok   = allow_sub ? sub : '0;
  assign state_nx = next_dev_state(state, sub_ok, resume_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= {1'b0, STG_POWERED};
    else        state <= state_nx;
  end

  AST_DEVST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_sub && !resume_ok) |=> $stable(state)); // R7
  AST_DEVST_BUSRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_sub && sub == 4'b0001) |=> (state == {1'b0, STG_DEFAULT})); // R7

endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
  import usbirq_pkg::*;
#(
  parameter int NPIPE = 10,
  parameter int DW    = (NPIPE > 8) ? NPIPE : 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             sleep_i,
  input  logic             ev_vbus,
  input  logic             ev_resume,
  input  logic             ev_sof,
  input  logic [3:0]       ev_dsub,
  input  logic [3:0]       ev_csub,
  input  logic [NPIPE-1:0] ev_brdy,
  input  logic [NPIPE-1:0] ev_nrdy,
  input  logic [NPIPE-1:0] ev_bemp,
  input  logic             ev_bchg,
  input  logic             ev_detach,
  input  logic             ev_setup_err,
  input  logic             ev_setup_ack,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [3:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             irq_n
);

  localparam int NKIND = 3; // 0 ready, 1 not-ready, 2 empty

  // write decode
  logic we_en0, we_en1, we_dsen, we_csen, we_sts0, we_sts1;
  assign we_en0  = wr_en && (wr_addr == A_EN0);
  assign we_en1  = wr_en && (wr_addr == A_EN1);
  assign we_dsen = wr_en && (wr_addr == A_DSEN);
  assign we_csen = wr_en && (wr_addr == A_CSEN);
  assign we_sts0 = wr_en && (wr_addr == A_STS0);
  assign we_sts1 = wr_en && (wr_addr == A_STS1);

  // source qualification
  logic [N0-1:0] live0;
  logic [N1-1:0] live1;
  logic          periph_awake;
  logic          pipes_awake;
  logic          resume_periph;
  assign live0         = live_mask0(host_mode, sleep_i);
  assign live1         = live_mask1(host_mode, sleep_i);
  assign periph_awake  = !host_mode && !sleep_i;
  assign pipes_awake   = !sleep_i;
  assign resume_periph = ev_resume && !host_mode;

  // per-pipe banks
  logic [NPIPE-1:0] pev  [NKIND];
  logic [NPIPE-1:0] pen  [NKIND];
  logic [NPIPE-1:0] psts [NKIND];
  logic [NKIND-1:0] phit;
  assign pev[0] = ev_brdy;
  assign pev[1] = ev_nrdy;
  assign pev[2] = ev_bemp;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    logic en_we_k, sts_we_k;
    assign en_we_k  = wr_en && (wr_addr == 4'(int'(A_BRDYEN) + k));
    assign sts_we_k = wr_en && (wr_addr == 4'(int'(A_BRDYSTS) + k));
    usbirq_pipe_bank #(.NPIPE(NPIPE)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .allow  (pipes_awake),
      .ev     (pev[k]),
      .en_we  (en_we_k),
      .sts_we (sts_we_k),
      .wdata  (wr_data[NPIPE-1:0]),
      .en     (pen[k]),
      .sts    (psts[k]),
      .hit    (phit[k])
    );
  end

  // sub-factor gates
  logic [NSUB-1:0] dsen, csen;
  logic            dvst_hit, ctrt_hit;

  usbirq_subgate #(.NSUB(NSUB)) u_dgate (
    .clk   (clk),
    .rst_n (rst_n),
    .allow (periph_awake),
    .ev    (ev_dsub),
    .en_we (we_dsen),
    .wdata (wr_data[NSUB-1:0]),
    .en    (dsen),
    .hit   (dvst_hit)
  );

  usbirq_subgate #(.NSUB(NSUB)) u_cgate (
    .clk   (clk),
    .rst_n (rst_n),
    .allow (periph_awake),
    .ev    (ev_csub),
    .en_we (we_csen),
    .wdata (wr_data[NSUB-1:0]),
    .en    (csen),
    .hit   (ctrt_hit)
  );

  // device state
  logic [2:0] dev_state;
  usbirq_devtrack u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .allow_sub (periph_awake),
    .sub       (ev_dsub),
    .resume_ok (resume_periph),
    .state     (dev_state)
  );

  // top-level status and enables
  logic [N0-1:0] en0, sts0, raw0, set0;
  logic [N1-1:0] en1, sts1, raw1, set1;
  logic          pend;

  always_comb begin
    raw0          = '0;
    raw0[S0_VBUS] = ev_vbus;
    raw0[S0_RESM] = ev_resume;
    raw0[S0_SOF]  = ev_sof;
    raw0[S0_DVST] = dvst_hit;
    raw0[S0_CTRT] = ctrt_hit;
    raw0[S0_BRDY] = phit[0];
    raw0[S0_NRDY] = phit[1];
    raw0[S0_BEMP] = phit[2];
    raw1          = '0;
    raw1[S1_BCHG] = ev_bchg;
    raw1[S1_DTCH] = ev_detach;
    raw1[S1_SERR] = ev_setup_err;
    raw1[S1_SACK] = ev_setup_ack;
  end

  assign set0 = raw0 & live0;
  assign set1 = raw1 & live1;
  assign pend = ((sts0 & en0 & live0) != '0) || ((sts1 & en1 & live1) != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0   <= '0;
      en1   <= '0;
      sts0  <= '0;
      sts1  <= '0;
      irq_n <= 1'b1;
    end else begin
      if (we_en0) en0 <= wr_data[N0-1:0];
      if (we_en1) en1 <= wr_data[N1-1:0];
      sts0  <= sticky8(sts0, we_sts0, wr_data[N0-1:0], set0);
      sts1  <= (we_sts1 ? (sts1 & wr_data[N1-1:0]) : sts1) | set1;
      irq_n <= !pend;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_EN0:     rd_data[N0-1:0]    = en0;
      A_EN1:     rd_data[N1-1:0]    = en1;
      A_DSEN:    rd_data[NSUB-1:0]  = dsen;
      A_CSEN:    rd_data[NSUB-1:0]  = csen;
      A_BRDYEN:  rd_data[NPIPE-1:0] = pen[0];
      A_NRDYEN:  rd_data[NPIPE-1:0] = pen[1];
      A_BEMPEN:  rd_data[NPIPE-1:0] = pen[2];
      A_STS0:    rd_data[N0-1:0]    = sts0;
      A_STS1:    rd_data[N1-1:0]    = sts1;
      A_BRDYSTS: rd_data[NPIPE-1:0] = psts[0];
      A_NRDYSTS: rd_data[NPIPE-1:0] = psts[1];
      A_BEMPSTS: rd_data[NPIPE-1:0] = psts[2];
      A_DEVST:   rd_data[2:0]       = dev_state;
      default:   rd_data            = '0;
    endcase
  end

  AST_PIN_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !irq_n); // R4
  AST_PIN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> irq_n); // R4
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vbus |=> sts0[S0_VBUS]); // R3
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_sts0 && !wr_data[S0_SOF] && !ev_sof) |=> !sts0[S0_SOF]); // R3
  AST_HOST_NO_DVST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts0[S0_DVST]) |-> !$past(host_mode)); // R9
  AST_PERIPH_NO_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts1[S1_DTCH]) |-> $past(host_mode)); // R10
  AST_SLEEP_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts0[S0_SOF]) |-> !$past(sleep_i)); // R12
  AST_BCHG_ANY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bchg |=> sts1[S1_BCHG]); // R11

endmodule

// File: tb/sim_usb_irq_hub.sv
module sim_usb_irq_hub;

  localparam int NP       = 10;
  localparam int DWB      = 10;
  localparam int CLK_HALF = 5;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_mode = 1'b0;
  logic            sleep_i = 1'b0;
  logic            ev_vbus = 1'b0, ev_resume = 1'b0, ev_sof = 1'b0;
  logic [3:0]      ev_dsub = '0, ev_csub = '0;
  logic [NP-1:0]   ev_brdy = '0, ev_nrdy = '0, ev_bemp = '0;
  logic            ev_bchg = 1'b0, ev_detach = 1'b0, ev_setup_err = 1'b0, ev_setup_ack = 1'b0;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [DWB-1:0]  wr_data = '0;
  logic [3:0]      rd_addr = '0;
  logic [DWB-1:0]  rd_data;
  logic            irq_n;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #CLK_HALF clk = ~clk;

  usb_irq_hub #(.NPIPE(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .sleep_i(sleep_i),
    .ev_vbus(ev_vbus), .ev_resume(ev_resume), .ev_sof(ev_sof),
    .ev_dsub(ev_dsub), .ev_csub(ev_csub),
    .ev_brdy(ev_brdy), .ev_nrdy(ev_nrdy), .ev_bemp(ev_bemp),
    .ev_bchg(ev_bchg), .ev_detach(ev_detach), .ev_setup_err(ev_setup_err),
    .ev_setup_ack(ev_setup_ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = DWB'(d);
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic zero_ev();
    ev_vbus = 0; ev_resume = 0; ev_sof = 0; ev_dsub = '0; ev_csub = '0;
    ev_brdy = '0; ev_nrdy = '0; ev_bemp = '0;
    ev_bchg = 0; ev_detach = 0; ev_setup_err = 0; ev_setup_ack = 0;
  endtask

  // events must already be driven; one edge captures them
  task automatic fire();
    tick();
    zero_ev();
  endtask

  task automatic clean();
    host_mode = 0; sleep_i = 0;
    for (int a = 0; a < 12; a++) wr(4'(a), 0);
    tick();
  endtask

  task automatic t_reset();
    for (int a = 0; a <= 12; a++) chk_reg("R1 reset register", 4'(a), 0);
    chk("R1 reset irq_n", int'(irq_n), 1);
  endtask

  task automatic t_sticky();
    clean();
    wr(4'd0, 'h01);                      // enable VBUS
    ev_vbus = 1; fire();
    chk_reg("R2 vbus status set", 4'd7, 'h01);
    chk("R4 pin one edge later (not yet)", int'(irq_n), 1);
    tick();
    chk("R4 pin low", int'(irq_n), 0);
    tick(); tick();
    chk_reg("R2 status sticky", 4'd7, 'h01);
  endtask

  task automatic t_clear();
    clean();
    ev_resume = 1; ev_sof = 1; ev_vbus = 1; fire();
    chk_reg("R2 three bits set", 4'd7, 'h07);
    wr(4'd7, 'h3FE);                     // zero at bit0 only
    chk_reg("R3 write zero clears, ones keep", 4'd7, 'h06);
    ev_vbus = 1;
    wr(4'd7, 'h000);
    zero_ev();
    chk_reg("R3 event wins over clear", 4'd7, 'h01);
    wr(4'd7, 0);
    chk_reg("R3 full clear", 4'd7, 0);
  endtask

  task automatic t_gate();
    clean();
    ev_sof = 1; fire();
    tick();
    chk("R4 disabled source keeps pin high", int'(irq_n), 1);
    wr(4'd0, 'h04);
    chk("R4 pin waits one edge after enable", int'(irq_n), 1);
    tick();
    chk("R4 enabled source pulls pin", int'(irq_n), 0);
    wr(4'd7, 0);
    tick();
    chk("R4 pin releases after clear", int'(irq_n), 1);
  endtask

  task automatic t_pipes();
    clean();
    wr(4'd4, 'h008);                     // ready: pipe 3 enabled
    ev_brdy = 10'h020; fire();
    chk_reg("R5 pipe5 status set while disabled", 4'd9, 'h020);
    chk_reg("R5 composite not set by disabled pipe", 4'd7, 'h00);
    ev_brdy = 10'h008; fire();
    chk_reg("R5 composite set by enabled pipe", 4'd7, 'h80);
    wr(4'd9, 'h3DF);
    chk_reg("R5 per-pipe clear by zero", 4'd9, 'h008);
    wr(4'd6, 'h200);                     // empty: pipe 9
    ev_bemp = 10'h200; ev_nrdy = 10'h001; fire();
    chk_reg("R5 empty composite", 4'd7, 'hA0);
    chk_reg("R5 not-ready pipe status", 4'd10, 'h001);
    chk_reg("R5 empty pipe status", 4'd11, 'h200);
  endtask

  task automatic t_dvst();
    clean();
    wr(4'd2, 'h4);                       // only configured sub-factor
    ev_dsub = 4'b0001; fire();
    chk_reg("R7 bus reset gives default", 4'd12, 1);
    chk_reg("R6 disabled sub-factor no status", 4'd7, 0);
    ev_dsub = 4'b0010; fire();
    chk_reg("R7 address stage", 4'd12, 2);
    ev_dsub = 4'b0100; fire();
    chk_reg("R7 configured stage", 4'd12, 3);
    chk_reg("R6 enabled sub-factor sets status", 4'd7, 'h08);
    ev_dsub = 4'b1000; fire();
    chk_reg("R7 suspend flag", 4'd12, 7);
    ev_resume = 1; fire();
    chk_reg("R7 resume clears suspend", 4'd12, 3);
    ev_dsub = 4'b0110; fire();
    chk_reg("R7 configured beats address", 4'd12, 3);
  endtask

  task automatic t_ctrt();
    clean();
    wr(4'd3, 'h8);                       // only sequence error
    ev_csub = 4'b0111; fire();
    chk_reg("R8 disabled sub-factors no status", 4'd7, 0);
    ev_csub = 4'b1000; fire();
    chk_reg("R8 sequence error sets status", 4'd7, 'h10);
  endtask

  task automatic t_host();
    clean();
    ev_dsub = 4'b0001; fire();           // default stage, peripheral
    wr(4'd2, 'hF); wr(4'd3, 'hF);
    ev_csub = 4'b0001; fire();           // control-stage status, enable off
    host_mode = 1;
    wr(4'd0, 'hFF);
    tick();
    chk("R9 stored control status masked in host", int'(irq_n), 1);
    ev_dsub = 4'b0100; ev_csub = 4'b1000; fire();
    chk_reg("R9 no new device-state status in host", 4'd7, 'h10);
    chk_reg("R9 device state frozen in host", 4'd12, 1);
    wr(4'd1, 'hE);
    ev_detach = 1; ev_setup_err = 1; ev_setup_ack = 1; fire();
    chk_reg("R10 host-only sources set", 4'd8, 'hE);
    tick();
    chk("R10 host-only sources pull pin", int'(irq_n), 0);
    wr(4'd8, 0);
    wr(4'd0, 0);
    host_mode = 0;
    ev_detach = 1; ev_setup_err = 1; ev_setup_ack = 1; fire();
    chk_reg("R10 ignored in peripheral", 4'd8, 0);
  endtask

  task automatic t_bchg();
    clean();
    wr(4'd1, 'h1);
    host_mode = 1;
    ev_bchg = 1; fire();
    chk_reg("R11 bus change in host", 4'd8, 1);
    tick();
    chk("R11 pin in host", int'(irq_n), 0);
    wr(4'd8, 0);
    host_mode = 0;
    ev_bchg = 1; fire();
    chk_reg("R11 bus change in peripheral", 4'd8, 1);
    tick();
    chk("R11 pin in peripheral", int'(irq_n), 0);
  endtask

  task automatic t_sleep();
    clean();
    ev_dsub = 4'b0001; fire();           // device state default
    wr(4'd0, 'h04);
    ev_sof = 1; fire();
    tick();
    chk("R12 awake SOF pulls pin", int'(irq_n), 0);
    sleep_i = 1;
    tick(); tick();
    chk("R12 SOF masked from pin while asleep", int'(irq_n), 1);
    wr(4'd7, 0);
    wr(4'd0, 'hFF); wr(4'd2, 'hF); wr(4'd4, 'h3FF);
    ev_sof = 1; ev_brdy = 10'h3FF; ev_dsub = 4'b0100; ev_csub = 4'hF; fire();
    chk_reg("R12 other sources ignored", 4'd7, 0);
    chk_reg("R12 pipe status untouched", 4'd9, 0);
    chk_reg("R12 device state untouched", 4'd12, 1);
    ev_vbus = 1; ev_resume = 1; fire();
    chk_reg("R12 wake sources still set", 4'd7, 'h03);
    wr(4'd1, 'h1);
    ev_bchg = 1; fire();
    chk_reg("R12 bus change while asleep", 4'd8, 1);
    tick();
    chk("R12 pin from wake source", int'(irq_n), 0);
    sleep_i = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    zero_ev();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sticky();
    t_clear();
    t_gate();
    t_pipes();
    t_dvst();
    t_ctrt();
    t_host();
    t_bchg();
    t_sleep();
    finish_run();
  end

endmodule